// File: doc/BRIEF.md
# X-Masked Multi-Chain Signature Compactor

This block collects the responses of several parallel scan chains during self-test and folds them into one signature word. Each chain contributes one scan-out bit per shift cycle. Before a bit reaches the signature register it goes through an AND gate driven by a mask bit. A mask bit of 0 replaces the response with 0, so an unknown value never reaches the register. A mask bit of 1 lets the response through. The mask comes from outside the block. It is either one shared bit that covers every chain or a vector with one bit for each chain, and a select input picks between the two on every cycle.

The signature register is as wide as the number of chains. It is a multiple-input shift register whose feedback comes from its top stage and follows a primitive polynomial set by a parameter. It moves only on cycles where the shift-valid input is high, and it keeps its value during capture cycles. A seed load sets a starting value. An end-of-test strobe compares the current signature with a golden value supplied from outside and holds the pass/fail result until the next strobe or seed load.

Top module: `xmask_misr`

## Requirements
- R1: After reset the signature is 0, and result_valid and result_pass are both 0.
- R2: When seed_load is high at a clock edge, the signature takes seed_val at that edge, even if shift_vld is also high.
- R3: When shift_vld is high and seed_load is low, every stage i takes the XOR of three terms: masked input bit i, stage i-1 (0 for stage 0), and stage N-1 if bit i of FB_TAPS is set. The default FB_TAPS 4'b0011 encodes x^4+x+1, so stage 3 feeds stages 0 and 1.
- R4: When shift_vld and seed_load are both low, the signature keeps its value whatever the chain inputs are.
- R5: When mask_sel_vec is 0, mask_all gates every chain. A mask_all of 0 makes all masked inputs 0, and a mask_all of 1 passes all chain bits.
- R6: When mask_sel_vec is 1, bit i of mask_vec gates chain i on its own (0 blocks, 1 passes).
- R7: A chain bit whose mask is 0 has no effect on the signature. The signature is the same as when that bit is driven 0.
- R8: When test_end is high at an edge, result_valid becomes 1 at that edge and result_pass becomes 1 exactly when the signature held before that edge equals golden. Both keep their values until the next test_end or seed_load.
- R9: A seed_load clears result_valid and result_pass at the same edge that loads the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chain_out | input | NUM_CHAINS | Scan-out bit of each chain |
| mask_all | input | 1 | Shared mask bit (1 = pass) |
| mask_vec | input | NUM_CHAINS | Per-chain mask bits (1 = pass) |
| mask_sel_vec | input | 1 | 0 selects mask_all, 1 selects mask_vec |
| shift_vld | input | 1 | Advance the signature this cycle |
| seed_load | input | 1 | Load seed_val and clear the result |
| seed_val | input | NUM_CHAINS | Starting signature |
| test_end | input | 1 | Compare the signature with golden |
| golden | input | NUM_CHAINS | Fault-free signature |
| signature | output | NUM_CHAINS | Current signature register |
| result_valid | output | 1 | A comparison has been made |
| result_pass | output | 1 | Last comparison matched golden |

## Verification
The hardest case to reach from the ports is a long run in which blocked chains carry values that would change the signature if they got through. The bench drives those blocked positions with changing non-zero junk, standing in for unknowns, in both the shared and the per-chain mask modes. It steps a model in which those positions are forced to 0 and requires the two signatures to match on every cycle. A one-step sweep covers every data and mask combination from varied seeds, and the end-of-test compare is exercised with both a matching and a non-matching golden value.

// File: rtl/xm_pkg.sv
package xm_pkg;
   typedef enum logic {
      MASK_SHARED = 1'b0,
      MASK_VECTOR = 1'b1
   } mask_src_e;
endpackage

// File: rtl/xm_mask_unit.sv
module xm_mask_unit #(
   parameter int NUM_CHAINS   = 4,
   parameter bit HAS_VEC_MASK = 1'b1
) (
   input  logic [NUM_CHAINS-1:0] chain_bits,
   input  logic                  mask_all,
   input  logic [NUM_CHAINS-1:0] mask_vec,
   input  logic                  mask_sel_vec,
   output logic [NUM_CHAINS-1:0] gated
);
   logic [NUM_CHAINS-1:0] eff_mask;

   generate
      if (HAS_VEC_MASK) begin : g_vec
         xm_pkg::mask_src_e src;
         assign src = xm_pkg::mask_src_e'(mask_sel_vec);
         assign eff_mask = (src == xm_pkg::MASK_VECTOR) ? mask_vec
                                                         : {NUM_CHAINS{mask_all}};
      end else begin : g_shared
         assign eff_mask = {NUM_CHAINS{mask_all}};
      end
   endgenerate

   // one AND gate per chain in front of the register
   for (genvar i = 0; i < NUM_CHAINS; i++) begin : g_and
      assign gated[i] = chain_bits[i] & eff_mask[i];
   end
endmodule

// File: rtl/xm_misr_core.sv
module xm_misr_core #(
   parameter int                  WIDTH = 4,
   parameter logic [WIDTH-1:0]    TAPS  = {{(WIDTH-2){1'b0}}, 2'b11}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_load,
   input  logic [WIDTH-1:0] seed_val,
   input  logic             shift_vld,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] sig
);
   localparam int TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_w
      $error("xm_misr_core: WIDTH must be at least 2");
   end
   if (TAPS[0] != 1'b1) begin : g_chk_t
      $error("xm_misr_core: TAPS bit 0 must be set");
   end

   logic [WIDTH-1:0] sig_q, sig_nxt;
   logic             fb;

   assign fb = sig_q[TOP];
   assign sig_nxt[0] = din[0] ^ (TAPS[0] & fb);
   for (genvar i = 1; i < WIDTH; i++) begin : g_stage
      assign sig_nxt[i] = sig_q[i-1] ^ din[i] ^ (TAPS[i] & fb);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sig_q <= '0;
      else if (seed_load)  sig_q <= seed_val;
      else if (shift_vld)  sig_q <= sig_nxt;
   end

   assign sig = sig_q;

   assert_capture_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_vld && !seed_load) |=> $stable(sig_q));

   assert_seed_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> (sig_q == $past(seed_val)));
endmodule

// File: rtl/xm_sig_check.sv
module xm_sig_check #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_load,
   input  logic             test_end,
   input  logic [WIDTH-1:0] sig,
   input  logic [WIDTH-1:0] golden,
   output logic             res_valid,
   output logic             res_pass
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_pass  <= 1'b0;
      end else if (seed_load) begin
         res_valid <= 1'b0;
         res_pass  <= 1'b0;
      end else if (test_end) begin
         res_valid <= 1'b1;
         res_pass  <= (sig == golden);
      end
   end

   assert_valid_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid) |-> $past(test_end));

   assert_pass_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_pass |-> res_valid);

   assert_seed_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> (!res_valid && !res_pass));
endmodule

// File: rtl/xmask_misr.sv
module xmask_misr #(
   parameter int                       NUM_CHAINS   = 4,
   parameter bit                       HAS_VEC_MASK = 1'b1,
   parameter logic [NUM_CHAINS-1:0]    FB_TAPS      = {{(NUM_CHAINS-2){1'b0}}, 2'b11}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CHAINS-1:0] chain_out,
   input  logic                  mask_all,
   input  logic [NUM_CHAINS-1:0] mask_vec,
   input  logic                  mask_sel_vec,
   input  logic                  shift_vld,
   input  logic                  seed_load,
   input  logic [NUM_CHAINS-1:0] seed_val,
   input  logic                  test_end,
   input  logic [NUM_CHAINS-1:0] golden,
   output logic [NUM_CHAINS-1:0] signature,
   output logic                  result_valid,
   output logic                  result_pass
);
   logic [NUM_CHAINS-1:0] gated;

   xm_mask_unit #(
      .NUM_CHAINS  (NUM_CHAINS),
      .HAS_VEC_MASK(HAS_VEC_MASK)
   ) u_mask (
      .chain_bits  (chain_out),
      .mask_all    (mask_all),
      .mask_vec    (mask_vec),
      .mask_sel_vec(mask_sel_vec),
      .gated       (gated)
   );

   xm_misr_core #(
      .WIDTH(NUM_CHAINS),
      .TAPS (FB_TAPS)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_load(seed_load),
      .seed_val (seed_val),
      .shift_vld(shift_vld),
      .din      (gated),
      .sig      (signature)
   );

   xm_sig_check #(
      .WIDTH(NUM_CHAINS)
   ) u_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .seed_load(seed_load),
      .test_end (test_end),
      .sig      (signature),
      .golden   (golden),
      .res_valid(result_valid),
      .res_pass (result_pass)
   );

   // an all-blocked shift from the zero state must stay at zero
   assert_blocked_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_vld && !seed_load && gated == '0 && signature == '0) |=> (signature == '0));
endmodule

// File: tb/test_xmask_misr.sv
`timescale 1ns/1ps
module test_xmask_misr;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] chain_out = '0, mask_vec = '0, seed_val = '0, golden = '0;
   logic         mask_all = 1'b0, mask_sel_vec = 1'b0;
   logic         shift_vld = 1'b0, seed_load = 1'b0, test_end = 1'b0;
   logic [N-1:0] signature;
   logic         result_valid, result_pass;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2.5 clk = ~clk;

   xmask_misr i_xmask_misr (
      .clk(clk), .rst_n(rst_n), .chain_out(chain_out), .mask_all(mask_all),
      .mask_vec(mask_vec), .mask_sel_vec(mask_sel_vec), .shift_vld(shift_vld),
      .seed_load(seed_load), .seed_val(seed_val), .test_end(test_end),
      .golden(golden), .signature(signature), .result_valid(result_valid),
      .result_pass(result_pass)
   );

   // model of R3 with taps x^4+x+1
   function automatic logic [N-1:0] model_step(logic [N-1:0] s, logic [N-1:0] d);
      logic [N-1:0] taps = 4'b0011;
      logic [N-1:0] r;
      r[0] = d[0] ^ (taps[0] & s[N-1]);
      for (int i = 1; i < N; i++) r[i] = s[i-1] ^ d[i] ^ (taps[i] & s[N-1]);
      return r;
   endfunction

   task automatic check(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      shift_vld = 0; seed_load = 0; test_end = 0;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      logic [N-1:0] ref_sig;
      logic [N-1:0] m_eff;
      // R1 reset state
      #7;
      check("R1 sig", signature, 0);
      check("R1 valid", result_valid, 0);
      check("R1 pass", result_pass, 0);
      @(negedge clk);
      rst_n = 1;
      tick();
      check("R1 sig after release", signature, 0);

      // one-step sweep over both mask sources, all masks and data
      for (int mode = 0; mode < 2; mode++) begin
         for (int m = 0; m < 16; m++) begin
            if (mode == 0 && m > 1) continue;
            for (int d = 0; d < 16; d++) begin
               logic [N-1:0] sd;
               sd = N'((d * 5 + m * 3 + mode) % 16);
               // load seed, with shift also high: seed must win (R2)
               seed_load = 1; shift_vld = 1; seed_val = sd; chain_out = N'(d);
               mask_sel_vec = mode[0];
               mask_all = m[0];
               mask_vec = N'(m);
               tick();
               check("R2 seed", signature, sd);
               m_eff = (mode == 1) ? N'(m) : {N{m[0]}};
               seed_load = 0; shift_vld = 1;
               tick();
               check(mode == 1 ? "R6 vec mask step" : "R5 shared mask step",
                     signature, model_step(sd, N'(d) & m_eff));
               // hold with different data (R4)
               shift_vld = 0; chain_out = ~N'(d);
               tick();
               check("R4 hold", signature, model_step(sd, N'(d) & m_eff));
            end
         end
      end

      // R7: long run with junk on blocked positions, both modes
      for (int mode = 0; mode < 2; mode++) begin
         idle();
         seed_load = 1; seed_val = 4'h9;
         mask_sel_vec = mode[0];
         tick();
         ref_sig = 4'h9;
         seed_load = 0;
         for (int k = 0; k < 40; k++) begin
            logic [N-1:0] live, junk;
            if (mode == 1) m_eff = N'(k % 7 == 0 ? 4'b0101 : 4'b1010 ^ N'(k % 3));
            else           m_eff = {N{k[2]}};
            mask_vec = m_eff;
            mask_all = k[2];
            live = N'((k * 11 + 3) % 16);
            junk = ~m_eff & N'((k * 13 + 7) % 16 | 1);
            chain_out = (live & m_eff) | junk;
            shift_vld = (k % 5 != 4);
            tick();
            if (k % 5 != 4) ref_sig = model_step(ref_sig, live & m_eff);
            check("R7 masked junk ignored", signature, ref_sig);
         end
         // R8 matching compare
         idle();
         golden = ref_sig; test_end = 1;
         tick();
         check("R8 valid", result_valid, 1);
         check("R8 pass", result_pass, 1);
         // result holds while signature moves on
         test_end = 0; shift_vld = 1; chain_out = 4'hF; mask_sel_vec = 0; mask_all = 1;
         tick();
         check("R8 held valid", result_valid, 1);
         check("R8 held pass", result_pass, 1);
         // non-matching compare
         idle();
         golden = ~signature; test_end = 1;
         tick();
         check("R8 mismatch valid", result_valid, 1);
         check("R8 mismatch pass", result_pass, 0);
         // matching again after a fail
         golden = signature; test_end = 1;
         tick();
         check("R8 rematch pass", result_pass, 1);
         // R9 seed load clears result
         test_end = 0; seed_load = 1; seed_val = 4'h3;
         tick();
         check("R9 valid cleared", result_valid, 0);
         check("R9 pass cleared", result_pass, 0);
         idle();
      end

      // R5: shared mask 0 from zero state keeps zero with all-ones data
      seed_load = 1; seed_val = 0;
      tick();
      seed_load = 0; shift_vld = 1; mask_sel_vec = 0; mask_all = 0; chain_out = 4'hF;
      mask_vec = 4'hF;
      tick();
      tick();
      check("R5 shared block keeps zero", signature, 0);
      idle();
      tick();

      done = 1'b1;
      finish_run();
   end
endmodule